// File: doc/BRIEF.md
# Alpha-Beta Tracker with Residual Gating and Lead-Point Output

This block follows a moving point in two dimensions. For each of X and Y it keeps a position and a velocity estimate in signed Q8.8 fixed point. On every measurement strobe it first predicts the next position as position plus velocity. It then takes the residual between the measured coordinate and that prediction.

If both residuals are within a configured limit, the estimates are corrected with unsigned alpha and beta gains. If either residual is beyond the limit, the sample is thrown away and the tracker coasts on its stored velocity. The sample is then treated as an outlier and never reaches the state.

On a measurement, or on an explicit request, the block produces a lead point, position plus velocity times a programmable step count. It is shown together with an externally computed confidence value. The valid strobe rises only when an external gate input confirms coherent motion.

Top module: `abp_tracker`

## Requirements
- R1: While reset is low and on the first cycle after it, pred_valid, pred_x, pred_y and pred_conf are all zero.
- R2: The first measurement after reset is never gated: it loads the position of each axis with the measured value and clears the velocity of that axis to zero.
- R3: For an accepted measurement on an axis with position p and velocity v: prediction q = sat(p+v), residual r = m−q, new position sat(q + floor(α·sat(r)/256)), new velocity sat(v + floor(β·sat(r)/256)).
- R4: A measurement is rejected when the residual of X or of Y lies outside −LIM..+LIM (LIM = 128 raw units by default, the limit itself accepted). On rejection both axes coast: position becomes sat(p+v) and velocity is unchanged.
- R5: The lead output of each axis is sat(p + v·dt), with dt an unsigned 4-bit step count and p, v the estimates after any measurement taken at the triggering edge.
- R6: A measurement strobe or a request strobe sampled at clock edge N updates pred_x, pred_y and pred_conf at edge N+1. At that edge pred_valid takes the value of conf_ok, so it is high for one cycle only if conf_ok is high then.
- R7: Every sum saturates to the signed 16-bit range −32768..32767 and never wraps.
- R8: Positions, velocities and measurements are signed Q8.8 (8 fractional bits). alpha and beta are unsigned Q0.8 gains (value/256).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| meas_vld | input | 1 | Measurement strobe |
| meas_x | input | 16 | Measured X, signed Q8.8 |
| meas_y | input | 16 | Measured Y, signed Q8.8 |
| pred_req | input | 1 | Request a lead point without a measurement |
| alpha | input | 8 | Position gain, unsigned Q0.8 |
| beta | input | 8 | Velocity gain, unsigned Q0.8 |
| lead_dt | input | 4 | Extrapolation step count |
| conf_in | input | 8 | Confidence value passed to the output |
| conf_ok | input | 1 | Gate: coherent motion confirmed |
| pred_valid | output | 1 | Lead point valid strobe |
| pred_x | output | 16 | Lead point X, signed Q8.8 |
| pred_y | output | 16 | Lead point Y, signed Q8.8 |
| pred_conf | output | 8 | Confidence captured with the lead point |

## Verification
The hardest states to reach from the ports are a residual of exactly ±LIM or ±(LIM+1), and an estimate pinned at the 16-bit rails. Both depend on the internal prediction, which the ports never show directly. The bench therefore keeps its own arithmetic model of both axes. It places every measurement at a chosen offset from the modelled prediction, including the two boundary offsets on one axis at a time. To reach the rails it drives a long ramp of maximum accepted residuals with full beta gain and the largest step count.

// File: rtl/abp_pkg.sv
package abp_pkg;

  // Clamp a 32-bit signed value into the signed range of w bits.
  function automatic logic signed [31:0] clip_s(input logic signed [31:0] a,
                                                input int unsigned w);
    logic signed [31:0] hi;
    logic signed [31:0] lo;
    hi = (32'sd1 <<< (w - 1)) - 32'sd1;
    lo = -hi - 32'sd1;
    if (a > hi)      return hi;
    else if (a < lo) return lo;
    else             return a;
  endfunction

  // Multiply a signed residual by an unsigned fractional gain, floor-shifted.
  function automatic logic signed [31:0] gain_mul(input logic signed [31:0] r,
                                                  input logic [31:0] g,
                                                  input int unsigned frac);
    logic signed [31:0] p;
    p = r * $signed(g);
    return p >>> frac;
  endfunction

endpackage

// File: rtl/abp_axis.sv
module abp_axis
  import abp_pkg::*;
#(
  parameter int W    = 16,
  parameter int GW   = 8,
  parameter int FRAC = 8,
  parameter int LIM  = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic                load,
  input  logic                accept,
  input  logic signed [W-1:0] meas,
  input  logic [GW-1:0]       alpha,
  input  logic [GW-1:0]       beta,
  output logic signed [W-1:0] est_pos,
  output logic signed [W-1:0] est_vel,
  output logic                out_of_range
);

  localparam logic signed [31:0] LIM32 = 32'(LIM);

  logic signed [W-1:0] pos_q, vel_q;
  logic signed [31:0]  pos_pred32, diff32, resid32, pos_upd32, vel_upd32;
  logic                coast_evt;

  always_comb begin
    pos_pred32 = clip_s(32'(pos_q) + 32'(vel_q), W);
    diff32     = 32'(meas) - pos_pred32;
    resid32    = clip_s(diff32, W);
    pos_upd32  = clip_s(pos_pred32 + gain_mul(resid32, 32'(alpha), FRAC), W);
    vel_upd32  = clip_s(32'(vel_q) + gain_mul(resid32, 32'(beta), FRAC), W);
  end

  assign out_of_range = (diff32 > LIM32) || (diff32 < -LIM32);
  assign coast_evt    = step && !load && !accept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
      vel_q <= '0;
    end else if (step) begin
      if (load) begin
        pos_q <= meas;
        vel_q <= '0;
      end else if (accept) begin
        pos_q <= W'(pos_upd32);
        vel_q <= W'(vel_upd32);
      end else begin
        pos_q <= W'(pos_pred32);
      end
    end
  end

  assign est_pos = pos_q;
  assign est_vel = vel_q;

  AST_INIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    step && load |=> (est_vel == '0) && (est_pos == $past(meas))); // R2

  AST_COAST_VEL: assert property (@(posedge clk) disable iff (!rst_n)
    coast_evt |=> est_vel == $past(est_vel)); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load && accept && (resid32 >= 0) |=> 32'(est_pos) >= $past(pos_pred32)); // R7

endmodule

// File: rtl/abp_lead.sv
module abp_lead
  import abp_pkg::*;
#(
  parameter int W   = 16,
  parameter int DTW = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire,
  input  logic signed [W-1:0] pos,
  input  logic signed [W-1:0] vel,
  input  logic [DTW-1:0]      dt,
  output logic signed [W-1:0] lead
);

  logic signed [31:0] lead32;
  logic signed [W-1:0] lead_q;

  assign lead32 = clip_s(32'(pos) + 32'(vel) * $signed(32'(dt)), W);

  always_ff @(posedge clk) begin
    if (!rst_n)    lead_q <= '0;
    else if (fire) lead_q <= W'(lead32);
  end

  assign lead = lead_q;

  AST_LEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(lead)); // R5

  AST_LEAD_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (vel >= 0) |=> lead >= $past(pos)); // R7

endmodule

// File: rtl/abp_tracker.sv
module abp_tracker #(
  parameter int W    = 16,
  parameter int GW   = 8,
  parameter int FRAC = 8,
  parameter int DTW  = 4,
  parameter int CW   = 8,
  parameter int LIM  = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                meas_vld,
  input  logic signed [W-1:0] meas_x,
  input  logic signed [W-1:0] meas_y,
  input  logic                pred_req,
  input  logic [GW-1:0]       alpha,
  input  logic [GW-1:0]       beta,
  input  logic [DTW-1:0]      lead_dt,
  input  logic [CW-1:0]       conf_in,
  input  logic                conf_ok,
  output logic                pred_valid,
  output logic signed [W-1:0] pred_x,
  output logic signed [W-1:0] pred_y,
  output logic [CW-1:0]       pred_conf
);

  localparam int NAX = 2;

  logic                inited;
  logic                first_load;
  logic                reject;
  logic                trig_q;
  logic [NAX-1:0]      big;
  logic signed [W-1:0] meas_a [NAX];
  logic signed [W-1:0] pos_a  [NAX];
  logic signed [W-1:0] vel_a  [NAX];
  logic signed [W-1:0] lead_a [NAX];

  assign meas_a[0]  = meas_x;
  assign meas_a[1]  = meas_y;
  assign first_load = meas_vld && !inited;
  assign reject     = |big;

  for (genvar i = 0; i < NAX; i++) begin : g_axis
    abp_axis #(.W(W), .GW(GW), .FRAC(FRAC), .LIM(LIM)) u_axis (
      .clk(clk), .rst_n(rst_n), .step(meas_vld), .load(first_load),
      .accept(!reject), .meas(meas_a[i]), .alpha(alpha), .beta(beta),
      .est_pos(pos_a[i]), .est_vel(vel_a[i]), .out_of_range(big[i]));

    abp_lead #(.W(W), .DTW(DTW)) u_lead (
      .clk(clk), .rst_n(rst_n), .fire(trig_q), .pos(pos_a[i]),
      .vel(vel_a[i]), .dt(lead_dt), .lead(lead_a[i]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inited     <= 1'b0;
      trig_q     <= 1'b0;
      pred_valid <= 1'b0;
      pred_conf  <= '0;
    end else begin
      inited     <= inited | meas_vld;
      trig_q     <= meas_vld | pred_req;
      pred_valid <= trig_q & conf_ok;
      if (trig_q) pred_conf <= conf_in;
    end
  end

  assign pred_x = lead_a[0];
  assign pred_y = lead_a[1];

  AST_VALID_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |-> $past(conf_ok) && $past(trig_q)); // R6

  AST_VALID_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    meas_vld |=> ##1 (pred_valid == $past(conf_ok))); // R6

endmodule

// File: tb/tb_abp_tracker.sv
`timescale 1ns/1ps
module tb_abp_tracker;

  localparam int LIM = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic meas_vld = 1'b0;
  logic pred_req = 1'b0;
  logic signed [15:0] meas_x = '0, meas_y = '0;
  logic [7:0] alpha = 8'd64, beta = 8'd16;
  logic [3:0] lead_dt = 4'd1;
  logic [7:0] conf_in = 8'd0;
  logic conf_ok = 1'b1;
  logic pred_valid;
  logic signed [15:0] pred_x, pred_y;
  logic [7:0] pred_conf;

  int checks = 0, errors = 0;
  int mx_p = 0, mx_v = 0, my_p = 0, my_v = 0;
  bit inited = 0;
  bit last_rej = 0;
  int unsigned seed = 32'd12345;

  always #4 clk = ~clk;

  abp_tracker dut (
    .clk(clk), .rst_n(rst_n), .meas_vld(meas_vld), .meas_x(meas_x),
    .meas_y(meas_y), .pred_req(pred_req), .alpha(alpha), .beta(beta),
    .lead_dt(lead_dt), .conf_in(conf_in), .conf_ok(conf_ok),
    .pred_valid(pred_valid), .pred_x(pred_x), .pred_y(pred_y),
    .pred_conf(pred_conf));

  function automatic int sat(input int a);
    if (a > 32767) return 32767;
    if (a < -32768) return -32768;
    return a;
  endfunction

  function automatic int fl256(input int a);
    // floor division by 256, written without shifts
    if (a >= 0) return a / 256;
    return -((-a + 255) / 256);
  endfunction

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // model of one measurement (R2 R3 R4 R7)
  task automatic model_meas(input int mx, input int my);
    int qx, qy, dx, dy, rx, ry;
    qx = sat(mx_p + mx_v); qy = sat(my_p + my_v);
    dx = mx - qx; dy = my - qy;
    if (!inited) begin
      mx_p = mx; my_p = my; mx_v = 0; my_v = 0; inited = 1; last_rej = 0;
    end else if (dx > LIM || dx < -LIM || dy > LIM || dy < -LIM) begin
      mx_p = qx; my_p = qy; last_rej = 1;
    end else begin
      rx = sat(dx); ry = sat(dy);
      mx_p = sat(qx + fl256(int'(alpha) * rx));
      mx_v = sat(mx_v + fl256(int'(beta) * rx));
      my_p = sat(qy + fl256(int'(alpha) * ry));
      my_v = sat(my_v + fl256(int'(beta) * ry));
      last_rej = 0;
    end
  endtask

  task automatic check_out(input string tag);
    int ex, ey;
    ex = sat(mx_p + mx_v * int'(lead_dt));
    ey = sat(my_p + my_v * int'(lead_dt));
    chk({tag, " R5 lead x"}, int'(pred_x), ex);
    chk({tag, " R5 lead y"}, int'(pred_y), ey);
    chk("R6 valid", int'(pred_valid), int'(conf_ok));
    chk("R6 conf", int'(pred_conf), int'(conf_in));
  endtask

  // one strobe: drive at negedge, visible after the following edge (R6)
  task automatic apply(input bit is_meas, input int mx, input int my, input string tag);
    int cx, cy;
    cx = sat(mx); cy = sat(my);
    @(negedge clk);
    meas_vld = is_meas; pred_req = !is_meas;
    meas_x = 16'(cx); meas_y = 16'(cy);
    @(negedge clk);
    meas_vld = 0; pred_req = 0;
    if (is_meas) model_meas(cx, cy);
    @(negedge clk);
    check_out(tag);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", int'(pred_valid), 0);
    chk("R1 x", int'(pred_x), 0);
    chk("R1 y", int'(pred_y), 0);
    chk("R1 conf", int'(pred_conf), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 valid after release", int'(pred_valid), 0);

    // R2 first measurement loads directly, even if far away
    conf_in = 8'd77; lead_dt = 4'd3;
    apply(1, 5000, -7000, "R2");
    apply(0, 0, 0, "R2 req");   // velocity zero: lead equals position

    // R4 rejection on one axis only, at the exact boundary
    apply(1, mx_p + mx_v + LIM, my_p + my_v, "R4 edge accept");
    chk("R4 edge accepted", int'(last_rej), 0);
    apply(1, mx_p + mx_v, my_p + my_v + LIM + 1, "R4 y reject");
    chk("R4 y rejected", int'(last_rej), 1);
    apply(1, mx_p + mx_v - LIM - 1, my_p + my_v, "R4 x reject");
    chk("R4 x rejected", int'(last_rej), 1);

    // R6 gate low: valid stays low, coordinates still refresh
    conf_ok = 0; conf_in = 8'd9;
    apply(0, 0, 0, "R6 gate low");
    conf_ok = 1;

    // R3 R8 near-exhaustive sweep of offsets, gains and step counts
    for (int k = 0; k < 1500; k++) begin
      int ox, oy, sel;
      string tag;
      alpha = 8'(rnd()); beta = 8'(rnd()); lead_dt = 4'(rnd());
      conf_in = 8'(rnd()); conf_ok = (rnd() % 4) != 0;
      sel = int'(rnd() % 4);
      case (sel)
        0: begin ox = int'(rnd() % 257) - 128; oy = int'(rnd() % 257) - 128; end
        1: begin ox = (rnd() % 2) ? LIM : -LIM; oy = (rnd() % 2) ? LIM + 1 : -LIM - 1; end
        2: begin ox = (rnd() % 2) ? LIM + 1 : -LIM - 1; oy = (rnd() % 2) ? LIM : -LIM; end
        default: begin ox = int'(rnd() % 801) - 400; oy = int'(rnd() % 801) - 400; end
      endcase
      tag = (sel == 0) ? "R3 R8" : "R3 R4";
      apply((k % 7) != 6, mx_p + mx_v + ox, my_p + my_v + oy, tag);
    end

    // R7 ramp into the rails: X upward, Y downward
    alpha = 8'd255; beta = 8'd255; lead_dt = 4'd15; conf_ok = 1;
    for (int k = 0; k < 400; k++) begin
      apply(1, mx_p + mx_v + LIM, my_p + my_v - LIM, "R7 ramp");
    end
    chk("R7 x at rail", mx_p, 32767);
    chk("R7 y at rail", my_p, -32768);
    lead_dt = 4'd0;
    apply(0, 0, 0, "R7 dt0");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule